// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from memory to a byte-wide transmit stream under the control of a ring of descriptors that software prepares. Each descriptor is a 16-byte record. Word 0 carries an ownership flag, an end-of-ring flag, segment flags and a byte count. Word 3 carries the byte address of the data buffer. Word 1 and word 2 are never touched by the engine. Software fills descriptors, hands them over by setting the ownership flag, and then pulses the poll-demand input. The engine walks forward through the ring. For every descriptor it owns, it streams the buffer bytes out and then hands the descriptor back by writing word 0 with the ownership flag cleared. It stops at the first descriptor it does not own.

Memory is reached through a single word-wide request port. A request is held steady until `mem_ack_i` is seen in the same cycle, and read data is taken in that acknowledge cycle. The byte stream is valid/ready. A byte moves on every rising edge where `tx_valid_o` and `tx_ready_i` are both high. While `tx_valid_o` is high and `tx_ready_i` is low, the byte and its last flag stay frozen, and valid never drops until the byte is taken. The sink may hold ready low for any number of cycles. The engine never combines a memory request with a pending byte, so back-pressure simply stalls the walk.

The ring base is loaded through a write strobe. A completed descriptor and an empty ring are each reported by a one-cycle status pulse.

Top module: `txring_dma`

## Requirements
- R1: After reset, `tx_valid_o`, `mem_req_o`, `done_o` and `empty_o` are low, and the ring base and current descriptor pointer are both 0.
- R2: While the engine is idle, a `base_we_i` pulse loads `base_wdata_i` as the ring base and as the current pointer. While the engine is busy, the pulse has no effect.
- R3: A `poll_i` pulse while idle starts a read of word 0 at the current pointer. A pulse while busy has no effect.
- R4: If word 0 has bit 31 (ownership) clear, the engine pulses `empty_o` for one cycle, goes idle and keeps the same pointer. The next poll reads the same address again.
- R5: For an owned descriptor, the engine reads word 3 (pointer + 12) as the buffer address and takes the byte count from word 0 bits [13:0]. Word 1 and word 2 are never read.
- R6: The engine emits the counted bytes in increasing address order from any byte alignment. Byte k of a memory word is bits [8k+7:8k]. Each 4-byte-aligned word that the buffer covers is read exactly once.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, valid stays high and `tx_data_o` and `tx_last_o` stay stable.
- R8: `tx_last_o` is high on the final byte of a descriptor only when word 0 bit 28 (last segment) is set.
- R9: A byte count of zero emits no bytes, and the descriptor is still handed back.
- R10: Hand-back writes word 0 at the pointer with bit 31 cleared and every other bit unchanged. `done_o` pulses in the cycle after that write is acknowledged.
- R11: After hand-back, the pointer moves by 16, or returns to the ring base when word 0 bit 15 (end of ring) is set. The next descriptor is fetched without a new poll.
- R12: `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Ring base load strobe |
| base_wdata_i | input | 32 | Ring base byte address |
| poll_i | input | 1 | Poll-demand strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit sink ready |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of a last-segment descriptor |
| done_o | output | 1 | One-cycle pulse: descriptor handed back |
| empty_o | output | 1 | One-cycle pulse: descriptor not owned |

## Verification
After a poll is sampled, the word-0 read request appears in the next cycle. `empty_o` follows one cycle after an acknowledged read of an unowned word 0, and `done_o` one cycle after an acknowledged hand-back write. The first byte is valid one cycle after the buffer word read is acknowledged. The bench drives and samples on the falling edge, so it logs every memory handshake and byte transfer at the edge where it takes effect. Each scenario waits until the request and valid lines have been quiet for several cycles before comparing the logged addresses, bytes, pulse counts and memory contents. This makes the checks independent of stall and back-pressure patterns.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_W0,
    S_RD_W3,
    S_FETCH,
    S_SEND,
    S_WB
  } txring_state_e;
endpackage

// File: rtl/txring_desc_ptr.sv
module txring_desc_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16,
  parameter logic [AW-1:0] RESET_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          advance_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q;
  logic [AW-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RESET_BASE;
      cur_q  <= RESET_BASE;
    end else if (load_i) begin
      base_q <= load_addr_i;
      cur_q  <= load_addr_i;
    end else if (advance_i) begin
      cur_q  <= wrap_i ? base_q : cur_q + STEP;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/txring_lane_sel.sv
module txring_lane_sel #(
  parameter int DW = 32,
  localparam int NLANE  = DW / 8,
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [DW-1:0]     word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [7:0]        byte_o
);
  logic [7:0] lanes [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 14,
  parameter int OWN_BIT  = 31,
  parameter int WRAP_BIT = 15,
  parameter int LAST_BIT = 28,
  parameter int W3_OFF   = 12,
  localparam int NLANE  = DW / 8,
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_i,
  input  logic [AW-1:0]     cur_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_last_o,
  output logic [DW-1:0]     word_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              advance_o,
  output logic              wrap_o,
  output logic              idle_o,
  output logic              done_o,
  output logic              empty_o
);
  localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

  txring_state_e state_q;
  logic [DW-1:0]    w0_q;
  logic [AW-1:0]    baddr_q;
  logic [LEN_W-1:0] left_q;
  logic [DW-1:0]    word_q;
  logic             done_q, empty_q;
  logic             final_byte;

  assign final_byte = (left_q == LEN_W'(1));

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_i;
    mem_wdata_o = w0_q & ~OWN_MASK;
    unique case (state_q)
      S_RD_W0: mem_req_o = 1'b1;
      S_RD_W3: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_i + AW'(W3_OFF);
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {baddr_q[AW-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      w0_q    <= '0;
      baddr_q <= '0;
      left_q  <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      empty_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (poll_i) state_q <= S_RD_W0;
        S_RD_W0: if (mem_ack_i) begin
          w0_q <= mem_rdata_i;
          if (mem_rdata_i[OWN_BIT]) begin
            state_q <= S_RD_W3;
          end else begin
            empty_q <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_RD_W3: if (mem_ack_i) begin
          baddr_q <= mem_rdata_i[AW-1:0];
          left_q  <= w0_q[LEN_W-1:0];
          state_q <= (w0_q[LEN_W-1:0] == '0) ? S_WB : S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          state_q <= S_SEND;
        end
        S_SEND: if (tx_ready_i) begin
          baddr_q <= baddr_q + AW'(1);
          left_q  <= left_q - LEN_W'(1);
          if (final_byte)                          state_q <= S_WB;
          else if (baddr_q[LANE_W-1:0] == '1)      state_q <= S_FETCH;
        end
        S_WB: if (mem_ack_i) begin
          done_q  <= 1'b1;
          state_q <= S_RD_W0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (state_q == S_SEND);
  assign tx_last_o  = tx_valid_o && final_byte && w0_q[LAST_BIT];
  assign word_o     = word_q;
  assign lane_o     = baddr_q[LANE_W-1:0];
  assign advance_o  = (state_q == S_WB) && mem_ack_i;
  assign wrap_o     = w0_q[WRAP_BIT];
  assign idle_o     = (state_q == S_IDLE);
  assign done_o     = done_q;
  assign empty_o    = empty_q;

  // R6: a byte is never offered while a memory access is outstanding
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && mem_req_o));

  // R9: a zero byte count goes straight from the buffer address read to hand-back
  a_r9_zero_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD_W3 && mem_ack_i && w0_q[LEN_W-1:0] == '0) |=> (mem_req_o && mem_we_o));
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = 14,
  parameter int DESC_BYTES = 16,
  parameter int OWN_BIT    = 31,
  parameter int WRAP_BIT   = 15,
  parameter int LAST_BIT   = 28,
  localparam int W3_OFF = 3 * (DW / 8),
  localparam int NLANE  = DW / 8,
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          poll_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          done_o,
  output logic          empty_o
);
  logic [AW-1:0]     cur;
  logic [DW-1:0]     word;
  logic [LANE_W-1:0] lane;
  logic              advance, wrap, idle;

  txring_desc_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_i(base_we_i && idle), .load_addr_i(base_wdata_i),
    .advance_i(advance), .wrap_i(wrap), .cur_o(cur)
  );

  txring_ctrl #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .OWN_BIT(OWN_BIT),
    .WRAP_BIT(WRAP_BIT), .LAST_BIT(LAST_BIT), .W3_OFF(W3_OFF)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .cur_i(cur),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_last_o(tx_last_o),
    .word_o(word), .lane_o(lane), .advance_o(advance), .wrap_o(wrap),
    .idle_o(idle), .done_o(done_o), .empty_o(empty_o)
  );

  txring_lane_sel #(.DW(DW)) u_lane (
    .word_i(word), .lane_i(lane), .byte_o(tx_data_o)
  );

  // R7: a stalled byte is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  // R12: an unacknowledged request is held unchanged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                   $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R10: completion pulse follows an acknowledged write that cleared ownership
  a_r10_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_req_o && mem_we_o && mem_ack_i) && !$past(mem_wdata_o[OWN_BIT])));

  // R4: empty pulse follows an acknowledged read of an unowned word
  a_r4_empty_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> $past(mem_req_o && !mem_we_o && mem_ack_i && !mem_rdata_i[OWN_BIT]));

  // R4, R10: the two status pulses never coincide
  a_r4_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, empty_o}));
endmodule

// File: tb/txring_dma_bench.sv
`timescale 1ns/1ps
module txring_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        poll = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0]  tx_data;
  logic        done_o, empty_o;

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  always #2.5 clk = ~clk;

  txring_dma u_txring_dma (
    .clk(clk), .rst_n(rst_n), .base_we_i(base_we), .base_wdata_i(base_wdata),
    .poll_i(poll), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .done_o(done_o), .empty_o(empty_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit stall_en = 0, bp_en = 0;
  logic [31:0] rd_log [64];
  logic [7:0]  by_log [64];
  bit          la_log [64];
  int rd_n = 0, by_n = 0, wr_n = 0, done_n = 0, empty_n = 0;

  // memory and sink responder: set handshake inputs, then log what the next edge takes
  initial forever begin
    @(negedge clk);
    cyc++;
    mem_ack  = mem_req && !(stall_en && (cyc % 3 == 0));
    tx_ready = !(bp_en && (cyc % 3 != 0));
    if (mem_req && mem_ack) begin
      if (mem_we) begin mem[mem_addr[9:2]] = mem_wdata; wr_n++; end
      else if (rd_n < 64) begin rd_log[rd_n] = mem_addr; rd_n++; end
    end
    if (tx_valid && tx_ready && by_n < 64) begin
      by_log[by_n] = tx_data; la_log[by_n] = tx_last; by_n++;
    end
    if (done_o)  done_n++;
    if (empty_o) empty_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    rd_n = 0; by_n = 0; wr_n = 0; done_n = 0; empty_n = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 6 && t < 5000) begin
      @(negedge clk); t++;
      if (!mem_req && !tx_valid && !done_o && !empty_o) q++; else q = 0;
    end
    if (t >= 5000) chk(0, "quiet timeout", t, 0);
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] a);
    @(negedge clk); base_we = 1'b1; base_wdata = a;
    @(negedge clk); base_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_w0(bit own, bit wrap, bit last, int len);
    logic [31:0] v = 32'(len) & 32'h3fff;
    v[15] = wrap; v[19] = 1'b1; v[28] = last; v[29] = 1'b1; v[31] = own;
    return v;
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] buf_a);
    mem[a[9:2]]     = w0;
    mem[a[9:2] + 1] = 32'h1111_0001;
    mem[a[9:2] + 2] = 32'h2222_0002;
    mem[a[9:2] + 3] = buf_a;
  endtask

  task automatic chk_reads(input string tag, input logic [31:0] exp [], input int n);
    chk(rd_n == n, {tag, " read count"}, rd_n, n);
    for (int i = 0; i < n && i < rd_n; i++)
      chk(rd_log[i] == exp[i], {tag, " read address"}, rd_log[i], exp[i]);
  endtask

  task automatic chk_bytes(input string tag, input logic [31:0] addrs [], input int n, input int last_idx);
    chk(by_n == n, {tag, " byte count"}, by_n, n);
    for (int i = 0; i < n && i < by_n; i++) begin
      chk(by_log[i] == (addrs[i][7:0] ^ 8'h5A), {tag, " byte value"}, by_log[i], addrs[i][7:0] ^ 8'h5A);
      chk(la_log[i] == (i == last_idx), {tag, " last flag"}, la_log[i], (i == last_idx));
    end
  endtask

  // R1: reset state, then the pointer starts at base 0
  task automatic t_reset();
    logic [31:0] e [] = '{32'h0};
    @(negedge clk);
    chk(!tx_valid && !mem_req && !done_o && !empty_o, "R1 reset outputs",
        {tx_valid, mem_req, done_o, empty_o}, 0);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R1 pointer at zero", e, 1);
    chk(empty_n == 1, "R1 empty pulse", empty_n, 1);
  endtask

  // R2, R4: base load, unowned descriptor idles on the same address
  task automatic t_unowned();
    logic [31:0] e [] = '{32'h100};
    set_base(32'h100); put_desc(32'h100, mk_w0(0, 0, 1, 4), 32'h200);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R2 base load", e, 1);
    chk(empty_n == 1 && wr_n == 0 && by_n == 0, "R4 idle no action", {empty_n, wr_n, by_n}, 32'h1);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R4 same descriptor again", e, 1);
  endtask

  // R5, R6, R8, R10, R11: aligned single descriptor
  task automatic t_basic();
    logic [31:0] e [] = '{32'h100, 32'h10C, 32'h200, 32'h204, 32'h110};
    logic [31:0] b [] = '{32'h200, 32'h201, 32'h202, 32'h203, 32'h204};
    logic [31:0] w0 = mk_w0(1, 0, 1, 5);
    put_desc(32'h100, w0, 32'h200);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R5 R11 basic", e, 5);
    chk_bytes("R6 R8 basic", b, 5, 4);
    chk(mem[32'h100 >> 2] == (w0 & 32'h7fff_ffff), "R10 owner cleared", mem[32'h100 >> 2], w0 & 32'h7fff_ffff);
    chk(done_n == 1 && empty_n == 1, "R10 pulses", {done_n, empty_n}, 32'h0001_0001);
  endtask

  // R6, R7, R12: unaligned buffer with stalls and back-pressure
  task automatic t_unaligned();
    logic [31:0] e [] = '{32'h110, 32'h11C, 32'h200, 32'h204, 32'h208, 32'h120};
    logic [31:0] b [] = '{32'h203, 32'h204, 32'h205, 32'h206, 32'h207, 32'h208};
    put_desc(32'h110, mk_w0(1, 0, 1, 6), 32'h203);
    stall_en = 1; bp_en = 1;
    clr_logs(); do_poll(); wait_quiet();
    stall_en = 0; bp_en = 0;
    chk_reads("R6 R12 unaligned", e, 6);
    chk_bytes("R6 R7 unaligned", b, 6, 5);
  endtask

  // R11: end-of-ring flag returns to base; descriptor past it untouched
  task automatic t_wrap();
    logic [31:0] e [] = '{32'h140, 32'h14C, 32'h210, 32'h150, 32'h15C, 32'h220,
                          32'h160, 32'h16C, 32'h230, 32'h140};
    logic [31:0] b [] = '{32'h210, 32'h220, 32'h221, 32'h231};
    set_base(32'h140);
    put_desc(32'h140, mk_w0(1, 0, 1, 1), 32'h210);
    put_desc(32'h150, mk_w0(1, 0, 1, 2), 32'h220);
    put_desc(32'h160, mk_w0(1, 1, 1, 1), 32'h231);
    put_desc(32'h170, mk_w0(1, 0, 1, 1), 32'h240);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R11 wrap", e, 10);
    chk(by_n == 4, "R11 wrap byte count", by_n, 4);
    chk(done_n == 3 && empty_n == 1, "R11 wrap pulses", {done_n, empty_n}, 32'h0003_0001);
    chk(mem[32'h170 >> 2][31], "R11 past-end untouched", mem[32'h170 >> 2], mk_w0(1, 0, 1, 1));
    if (by_n == 4) chk(by_log[3] == (8'h31 ^ 8'h5A), "R11 wrap last byte", by_log[3], 8'h31 ^ 8'h5A);
  endtask

  // R8, R9: no last-segment flag, then a zero-length descriptor
  task automatic t_nolast_zero();
    logic [31:0] e [] = '{32'h180, 32'h18C, 32'h240, 32'h190, 32'h19C, 32'h1A0};
    logic [31:0] b [] = '{32'h240, 32'h241, 32'h242};
    logic [31:0] w1 = mk_w0(1, 0, 1, 0);
    set_base(32'h180);
    put_desc(32'h180, mk_w0(1, 0, 0, 3), 32'h240);
    put_desc(32'h190, w1, 32'h250);
    put_desc(32'h1A0, 32'h0, 32'h0);
    clr_logs(); do_poll(); wait_quiet();
    chk_reads("R9 zero length", e, 6);
    chk_bytes("R8 no last flag", b, 3, -1);
    chk(mem[32'h190 >> 2] == (w1 & 32'h7fff_ffff) && done_n == 2, "R9 zero returned",
        mem[32'h190 >> 2], w1 & 32'h7fff_ffff);
  endtask

  // R2, R3: base write and poll while busy have no effect
  task automatic t_busy();
    logic [31:0] e [] = '{32'h1C0, 32'h1CC, 32'h260, 32'h264, 32'h1D0};
    set_base(32'h1C0);
    put_desc(32'h1C0, mk_w0(1, 0, 1, 8), 32'h260);
    put_desc(32'h1D0, 32'h0, 32'h0);
    bp_en = 1;
    clr_logs(); do_poll();
    repeat (6) @(negedge clk);
    base_we = 1'b1; base_wdata = 32'h0; poll = 1'b1;
    @(negedge clk); base_we = 1'b0; poll = 1'b0;
    wait_quiet(); bp_en = 0;
    chk_reads("R2 R3 busy ignored", e, 5);
    chk(empty_n == 1 && by_n == 8, "R3 single walk", {empty_n, by_n}, 32'h0001_0008);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int a = 32'h200; a < 32'h400; a++) mem[a >> 2][8*(a % 4) +: 8] = 8'(a) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unowned();
    t_basic();
    t_unaligned();
    t_wrap();
    t_nolast_zero();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule